// File: doc/BRIEF.md
# Paged Memory Expansion Card Decoder

This block is the glue logic of a paged memory expansion card for a 16-bit address bus. It splits the CPU address space into eight 8 KB regions and raises a memory-expansion select for the regions that the card backs with RAM. When an access control bit is set, it raises a register select for the 8 KB region where the page registers of an external mapper are reached. It also produces the strobes, register index and write word that the mapper needs, and chooses between mapped and transparent paging.

From the page number (taken from the mapper in map mode, or formed from the address in transparent mode) and the 4 KB offset, the block forms a 19-bit SRAM address and one of two chip selects. A chip-size input chooses between large chips and small chips. With small chips the two top page bits are ignored, so higher pages mirror lower ones. The write byte sent to the SRAM is bit-reversed, because the CPU numbers its data bits the opposite way. All outputs are registered and follow the inputs by one clock.

Top module: `expc_decoder`

## Requirements
- R1: `mexp_sel` is 1 exactly when `cpu_addr` lies in 0x2000–0x3FFF or 0xA000–0xFFFF. This means the 8 KB region `cpu_addr[15:13]` is 1, 5, 6 or 7.
- R2: `reg_sel` is 1 exactly when `cpu_addr` lies in 0x4000–0x5FFF and `ctl_reg_access` is 1.
- R3: `card_sel` equals `mexp_sel` OR `reg_sel`.
- R4: `map_mode` is 1 only when `mexp_sel` is 1 and `ctl_map_on` is 1. The effective page is `map_page` in map mode. Otherwise it is `{4'b0, cpu_addr[15:12]}` (transparent mode), so the window 0xN000 uses page N. `map_idx` always equals `cpu_addr[15:12]`.
- R5: `reg_idx` equals `cpu_addr[4:1]`, so the page registers sit at even byte addresses from 0x4000. `reg_we` is `reg_sel & wr_en`, and `reg_rd` is `reg_sel & dbin`.
- R6: `reg_wdata` is `{cpu_data, 4'b0000}`: the CPU byte fills the top 8 register bits and the low 4 bits are zero.
- R7: `sram_addr[11:0]` equals `cpu_addr[11:0]`.
- R8: With `big_chips`=1, effective page bit 7 selects the chip (0 gives `sram_cs`=2'b01, 1 gives 2'b10), and `sram_addr[18:12]` equals page bits 6..0.
- R9: With `big_chips`=0, page bit 5 selects the chip, `sram_addr[16:12]` equals page bits 4..0, and `sram_addr[18:17]` is held at 2'b11. Page bits 7..6 have no effect, so page 64 aliases page 0.
- R10: `sram_wdata[i]` equals `cpu_data[7-i]` for every bit i.
- R11: `sram_cs` is nonzero only when `mem_en` and `mexp_sel` are both 1, and it has at most one bit set. `sram_we` is `wr_en` and `sram_oe` is `dbin`, each gated by an active chip select.
- R12: While `rst_n` is 0, every output is 0. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address, bit 15 most significant |
| cpu_data | input | 8 | CPU write byte |
| mem_en | input | 1 | Memory cycle in progress |
| wr_en | input | 1 | Write cycle |
| dbin | input | 1 | Read cycle (data toward CPU) |
| ctl_reg_access | input | 1 | Control bit 0: opens the page registers at 0x4000 |
| ctl_map_on | input | 1 | Control bit 1: map mode instead of transparent mode |
| big_chips | input | 1 | 1 for large SRAM chips, 0 for small mirrored chips |
| map_page | input | 8 | Page number delivered by the mapper |
| mexp_sel | output | 1 | Memory-expansion region hit |
| reg_sel | output | 1 | Page register region hit |
| card_sel | output | 1 | Card responds |
| map_mode | output | 1 | Mapper in map mode |
| map_idx | output | 4 | Mapper register index for mapping |
| reg_idx | output | 4 | Mapper register index for access |
| reg_we | output | 1 | Page register write strobe |
| reg_rd | output | 1 | Page register read strobe |
| reg_wdata | output | 12 | Page register write word |
| sram_addr | output | 19 | SRAM address |
| sram_cs | output | 2 | SRAM chip selects, one per chip |
| sram_we | output | 1 | SRAM write enable |
| sram_oe | output | 1 | SRAM output enable |
| sram_wdata | output | 8 | Bit-reversed SRAM write byte |

## Verification
The region decode is swept with one address inside every 8 KB region, under all four settings of the two control bits. This separates the RAM regions from the register region and shows that the control-bit gating acts only where intended. Page routing is tried with pages whose bit 7, bit 6 or bit 5 alone is set, in both chip-size modes. This separates the chip-select bit from the top-address bits and shows the mirroring of page 64 onto page 0. Transparent and mapped accesses to the same window are compared, and asymmetric data bytes such as 0x01 and 0xC5 reveal any missing bit reversal. Accesses with `mem_en` low confirm that the chip selects and SRAM strobes stay quiet.

// File: rtl/expc_pkg.sv
package expc_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int PAGE_W  = 8;
    localparam int OFS_W   = 12;
    localparam int NIB_W   = ADDR_W - OFS_W;
    localparam int REG_W   = 12;
    localparam int SRAM_W  = 19;
    localparam int NCHIP   = 2;
    localparam int IDX_W   = 4;

    typedef struct packed {
        logic                mexp_sel;
        logic                reg_sel;
        logic                card_sel;
        logic                map_mode;
        logic [IDX_W-1:0]    map_idx;
        logic [IDX_W-1:0]    reg_idx;
        logic                reg_we;
        logic                reg_rd;
        logic [REG_W-1:0]    reg_wdata;
        logic [SRAM_W-1:0]   sram_addr;
        logic [NCHIP-1:0]    sram_cs;
        logic                sram_we;
        logic                sram_oe;
        logic [DATA_W-1:0]   sram_wdata;
    } dec_out_t;
endpackage

// File: rtl/expc_region_dec.sv
module expc_region_dec
    import expc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctl_reg_access,
    output logic              mexp_hit,
    output logic              reg_hit
);
    localparam int REG_BITS = 3;
    logic [REG_BITS-1:0] region;

    always_comb begin
        region   = addr[ADDR_W-1 -: REG_BITS];
        mexp_hit = 1'b0;
        reg_hit  = 1'b0;
        case (region)
            3'd1, 3'd5, 3'd6, 3'd7: mexp_hit = 1'b1;
            3'd2:                   reg_hit  = ctl_reg_access;
            default: ;
        endcase
    end
endmodule

// File: rtl/expc_page_route.sv
module expc_page_route
    import expc_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  offset,
    input  logic              big_chips,
    input  logic              enable,
    output logic [SRAM_W-1:0] sram_addr,
    output logic [NCHIP-1:0]  sram_cs
);
    localparam int BIG_HI   = SRAM_W - OFS_W;
    localparam int SMALL_HI = BIG_HI - 2;

    logic chip_bit;

    always_comb begin
        if (big_chips) begin
            chip_bit  = page[PAGE_W-1];
            sram_addr = {page[BIG_HI-1:0], offset};
        end else begin
            chip_bit  = page[SMALL_HI];
            sram_addr = {2'b11, page[SMALL_HI-1:0], offset};
        end
    end

    for (genvar c = 0; c < NCHIP; c++) begin : g_cs
        assign sram_cs[c] = enable && (chip_bit == c[0]);
    end
endmodule

// File: rtl/expc_byte_flip.sv
module expc_byte_flip
    import expc_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[DATA_W-1-i];
    end
endmodule

// File: rtl/expc_decoder.sv
module expc_decoder
    import expc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_data,
    input  logic                mem_en,
    input  logic                wr_en,
    input  logic                dbin,
    input  logic                ctl_reg_access,
    input  logic                ctl_map_on,
    input  logic                big_chips,
    input  logic [7:0]          map_page,
    output logic                mexp_sel,
    output logic                reg_sel,
    output logic                card_sel,
    output logic                map_mode,
    output logic [3:0]          map_idx,
    output logic [3:0]          reg_idx,
    output logic                reg_we,
    output logic                reg_rd,
    output logic [11:0]         reg_wdata,
    output logic [18:0]         sram_addr,
    output logic [1:0]          sram_cs,
    output logic                sram_we,
    output logic                sram_oe,
    output logic [7:0]          sram_wdata
);
    localparam int PAD_W = REG_W - DATA_W;

    logic              mexp_hit;
    logic              reg_hit;
    logic [PAGE_W-1:0] eff_page;
    logic              map_on;
    logic              cs_en;
    logic [SRAM_W-1:0] addr_c;
    logic [NCHIP-1:0]  cs_c;
    logic [DATA_W-1:0] flip_c;
    dec_out_t          out_d, out_q;

    expc_region_dec u_region (
        .addr           (cpu_addr),
        .ctl_reg_access (ctl_reg_access),
        .mexp_hit       (mexp_hit),
        .reg_hit        (reg_hit)
    );

    assign map_on   = mexp_hit && ctl_map_on;
    assign eff_page = map_on ? map_page
                             : {{(PAGE_W-NIB_W){1'b0}}, cpu_addr[ADDR_W-1 -: NIB_W]};
    assign cs_en    = mexp_hit && mem_en;

    expc_page_route u_route (
        .page      (eff_page),
        .offset    (cpu_addr[OFS_W-1:0]),
        .big_chips (big_chips),
        .enable    (cs_en),
        .sram_addr (addr_c),
        .sram_cs   (cs_c)
    );

    expc_byte_flip u_flip (
        .din  (cpu_data),
        .dout (flip_c)
    );

    always_comb begin
        out_d            = '0;
        out_d.mexp_sel   = mexp_hit;
        out_d.reg_sel    = reg_hit;
        out_d.card_sel   = mexp_hit || reg_hit;
        out_d.map_mode   = map_on;
        out_d.map_idx    = cpu_addr[ADDR_W-1 -: IDX_W];
        out_d.reg_idx    = cpu_addr[IDX_W:1];
        out_d.reg_we     = reg_hit && wr_en;
        out_d.reg_rd     = reg_hit && dbin;
        out_d.reg_wdata  = {cpu_data, {PAD_W{1'b0}}};
        out_d.sram_addr  = addr_c;
        out_d.sram_cs    = cs_c;
        out_d.sram_we    = (|cs_c) && wr_en;
        out_d.sram_oe    = (|cs_c) && dbin;
        out_d.sram_wdata = flip_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mexp_sel   = out_q.mexp_sel;
    assign reg_sel    = out_q.reg_sel;
    assign card_sel   = out_q.card_sel;
    assign map_mode   = out_q.map_mode;
    assign map_idx    = out_q.map_idx;
    assign reg_idx    = out_q.reg_idx;
    assign reg_we     = out_q.reg_we;
    assign reg_rd     = out_q.reg_rd;
    assign reg_wdata  = out_q.reg_wdata;
    assign sram_addr  = out_q.sram_addr;
    assign sram_cs    = out_q.sram_cs;
    assign sram_we    = out_q.sram_we;
    assign sram_oe    = out_q.sram_oe;
    assign sram_wdata = out_q.sram_wdata;
endmodule

// File: rtl/expc_decoder_chk.sv
module expc_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        mem_en,
    input logic        ctl_reg_access,
    input logic        ctl_map_on,
    input logic        big_chips,
    input logic        mexp_sel,
    input logic        reg_sel,
    input logic        card_sel,
    input logic        map_mode,
    input logic [18:0] sram_addr,
    input logic [1:0]  sram_cs,
    input logic [7:0]  sram_wdata
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_mexp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mexp_sel) |->
            (($past(cpu_addr) >= 16'h2000 && $past(cpu_addr) < 16'h4000) ||
             $past(cpu_addr) >= 16'hA000));

    a_r2_reg_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && reg_sel) |->
            ($past(ctl_reg_access) && $past(cpu_addr) >= 16'h4000 &&
             $past(cpu_addr) < 16'h6000));

    a_r3_card_union: assert property (@(posedge clk) disable iff (!rst_n)
        card_sel == (mexp_sel || reg_sel));

    a_r4_map_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && map_mode) |-> (mexp_sel && $past(ctl_map_on)));

    a_r7_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sram_cs != 2'b00) |-> sram_addr[11:0] == $past(cpu_addr[11:0]));

    a_r9_small_top_high: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sram_cs != 2'b00 && !$past(big_chips)) |-> sram_addr[18:17] == 2'b11);

    a_r10_flip_ends: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sram_wdata[0] == $past(cpu_data[7]) &&
                     sram_wdata[7] == $past(cpu_data[0])));

    a_r11_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sram_cs));

    a_r11_cs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sram_cs != 2'b00) |-> (mexp_sel && $past(mem_en)));
endmodule

bind expc_decoder expc_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_data       (cpu_data),
    .mem_en         (mem_en),
    .ctl_reg_access (ctl_reg_access),
    .ctl_map_on     (ctl_map_on),
    .big_chips      (big_chips),
    .mexp_sel       (mexp_sel),
    .reg_sel        (reg_sel),
    .card_sel       (card_sel),
    .map_mode       (map_mode),
    .sram_addr      (sram_addr),
    .sram_cs        (sram_cs),
    .sram_wdata     (sram_wdata)
);

// File: tb/expc_decoder_tb.sv
module expc_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mem_en = 1'b0, wr_en = 1'b0, dbin = 1'b0;
    logic        ctl_reg_access = 1'b0, ctl_map_on = 1'b0, big_chips = 1'b1;
    logic [7:0]  map_page = '0;
    logic        mexp_sel, reg_sel, card_sel, map_mode, reg_we, reg_rd;
    logic        sram_we, sram_oe;
    logic [3:0]  map_idx, reg_idx;
    logic [11:0] reg_wdata;
    logic [18:0] sram_addr;
    logic [1:0]  sram_cs;
    logic [7:0]  sram_wdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    expc_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mem_en(mem_en), .wr_en(wr_en), .dbin(dbin),
        .ctl_reg_access(ctl_reg_access), .ctl_map_on(ctl_map_on),
        .big_chips(big_chips), .map_page(map_page),
        .mexp_sel(mexp_sel), .reg_sel(reg_sel), .card_sel(card_sel),
        .map_mode(map_mode), .map_idx(map_idx), .reg_idx(reg_idx),
        .reg_we(reg_we), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .sram_addr(sram_addr), .sram_cs(sram_cs), .sram_we(sram_we),
        .sram_oe(sram_oe), .sram_wdata(sram_wdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic access(input logic [15:0] a, input logic [7:0] d,
                          input logic me, input logic w, input logic r,
                          input logic c0, input logic c1, input logic big,
                          input logic [7:0] pg);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; mem_en = me; wr_en = w; dbin = r;
        ctl_reg_access = c0; ctl_map_on = c1; big_chips = big; map_page = pg;
        @(negedge clk);
    endtask

    task automatic t_reset;
        access(16'hA000, 8'hFF, 1, 1, 0, 1, 1, 1, 8'hFF);
        rst_n = 1'b0;
        #1;
        chk("R12", "card_sel in reset", card_sel, 0);
        chk("R12", "sram_cs in reset", sram_cs, 0);
        chk("R12", "sram_wdata in reset", sram_wdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_regions;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 8; r++) begin
                logic [15:0] a;
                logic em, er;
                a  = 16'(r * 16'h2000 + 16'h0346);
                em = (r == 1) || (r >= 5);
                er = (r == 2) && c[0];
                access(a, 8'h00, 1, 0, 1, c[0], c[1], 1, 8'h00);
                chk("R1", "mexp_sel", mexp_sel, em);
                chk("R2", "reg_sel", reg_sel, er);
                chk("R3", "card_sel", card_sel, em | er);
                chk("R4", "map_mode", map_mode, em & c[1]);
                chk("R4", "map_idx", map_idx, a[15:12]);
            end
        end
    endtask

    task automatic t_reg_access;
        access(16'h401E, 8'hB7, 1, 1, 0, 1, 0, 1, 8'h00);
        chk("R5", "reg_idx", reg_idx, 4'hF);
        chk("R5", "reg_we", reg_we, 1);
        chk("R5", "reg_rd", reg_rd, 0);
        chk("R6", "reg_wdata", reg_wdata, 12'hB70);
        chk("R11", "no sram cs on reg", sram_cs, 0);
        access(16'h4004, 8'h01, 1, 0, 1, 1, 0, 1, 8'h00);
        chk("R5", "reg_idx 4004", reg_idx, 4'h2);
        chk("R5", "reg_rd", reg_rd, 1);
        chk("R6", "reg_wdata low", reg_wdata, 12'h010);
        access(16'h4004, 8'h01, 1, 1, 0, 0, 0, 1, 8'h00);
        chk("R2", "no reg_we when bit0 clear", reg_we, 0);
    endtask

    task automatic t_transparent;
        access(16'hA123, 8'h00, 1, 0, 1, 0, 0, 1, 8'h77);
        chk("R4", "transparent addr", sram_addr, {7'h0A, 12'h123});
        chk("R8", "transparent cs", sram_cs, 2'b01);
        chk("R11", "oe", sram_oe, 1);
        access(16'hA123, 8'h00, 1, 0, 1, 0, 1, 1, 8'h77);
        chk("R4", "mapped addr", sram_addr, {7'h77, 12'h123});
        chk("R7", "offset", sram_addr[11:0], 12'h123);
    endtask

    task automatic t_large;
        access(16'h2FFF, 8'h00, 1, 1, 0, 0, 1, 1, 8'h80);
        chk("R8", "bit7 chip", sram_cs, 2'b10);
        chk("R8", "bit7 addr", sram_addr, {7'h00, 12'hFFF});
        chk("R11", "we", sram_we, 1);
        access(16'h2FFF, 8'h00, 1, 1, 0, 0, 1, 1, 8'h40);
        chk("R8", "bit6 chip", sram_cs, 2'b01);
        chk("R8", "bit6 addr", sram_addr, {7'h40, 12'hFFF});
        access(16'h2FFF, 8'h00, 1, 1, 0, 0, 1, 1, 8'h20);
        chk("R8", "bit5 addr", sram_addr, {7'h20, 12'hFFF});
    endtask

    task automatic t_small;
        access(16'hF010, 8'h00, 1, 0, 1, 0, 1, 0, 8'h40);
        chk("R9", "page64 cs", sram_cs, 2'b01);
        chk("R9", "page64 aliases 0", sram_addr, {2'b11, 5'h00, 12'h010});
        access(16'hF010, 8'h00, 1, 0, 1, 0, 1, 0, 8'hC0);
        chk("R9", "page192 aliases 0", sram_addr, {2'b11, 5'h00, 12'h010});
        chk("R9", "page192 cs", sram_cs, 2'b01);
        access(16'hF010, 8'h00, 1, 0, 1, 0, 1, 0, 8'h3F);
        chk("R9", "bit5 chip", sram_cs, 2'b10);
        chk("R9", "page 3F addr", sram_addr, {2'b11, 5'h1F, 12'h010});
    endtask

    task automatic t_data_and_gate;
        access(16'hC000, 8'h01, 1, 1, 0, 0, 0, 1, 8'h00);
        chk("R10", "flip 01", sram_wdata, 8'h80);
        access(16'hC000, 8'hC5, 1, 1, 0, 0, 0, 1, 8'h00);
        chk("R10", "flip C5", sram_wdata, 8'hA3);
        access(16'hC000, 8'hC5, 0, 1, 0, 0, 0, 1, 8'h00);
        chk("R11", "cs without mem_en", sram_cs, 0);
        chk("R11", "we without mem_en", sram_we, 0);
        chk("R1", "mexp without mem_en", mexp_sel, 1);
        access(16'h6000, 8'hC5, 1, 1, 1, 1, 1, 1, 8'h00);
        chk("R11", "cs outside region", sram_cs, 0);
        chk("R11", "oe outside region", sram_oe, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset;
                t_regions;
                t_reg_access;
                t_transparent;
                t_large;
                t_small;
                t_data_and_gate;
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule